// File: doc/BRIEF.md
# Self-Timed Byte-Wide EEPROM Controller

This block models the control logic of an 8K x 8 electrically erasable memory behind an SRAM-style port. The port uses active-low strobes for select (`ce_n`), output gating (`oe_n`) and write (`we_n`). Everything is sampled on the system clock. A byte write latches its address and data. The bus is then free while an internal counter runs a clear phase and a program phase. `ready_o` is low for the whole cycle.

While the cycle runs, the host can find out when it is done in either of two ways. It can watch `ready_o`, or it can read back the byte it just wrote: the read returns the inverted top data bit until the real data is stored. Analog conditions are modelled as digital qualifiers: `low_vcc` blocks writes, `sig_hv` selects a 32-byte signature row at the top 32 addresses, and `clr_hv` turns a write strobe into a clear of the whole main array.

Top module: `eeprom_core`

## Requirements
- R1: The write strobe is `ce_n | we_n`. A write begins at the clock where this strobe is first seen low, and the address is taken at that clock. The data is taken at the clock where the strobe is first seen high again. Changes to `addr` after the start, and to `din` after the end, have no effect on what is stored.
- R2: `ready_o` is 1 out of reset and when idle. It goes to 0 on the clock after an accepted write begins. It returns to 1 exactly `WC_CYCLES` clocks after the strobe-rise clock.
- R3: While a byte cycle runs, a read of the latched address (same row select) returns bit 7 inverted from the written data, with bits 6..0 forced to 0. After the cycle ends, the true data is returned.
- R4: While a byte cycle runs, a read of any other location returns the stored contents.
- R5: A write start is ignored, leaving `ready_o` at 1 and the memory unchanged, when `oe_n` is 0 (without `clr_hv`) or when `low_vcc` is 1.
- R6: A write strobe seen while `ready_o` is 0 is ignored. The address and data already latched are the ones stored.
- R7: With `sig_hv` at 1, addresses 0x1FE0..0x1FFF read and write a separate 32-byte row indexed by `addr[4:0]`. With `sig_hv` at 0 the same addresses reach the main array.
- R8: A write start with `clr_hv` at 1 sets every main-array byte to 0xFF over 8192 clocks, holding `ready_o` at 0. The signature row is left unchanged.
- R9: Reads have one clock of latency. `dout_oe` is 1 on the clock after `ce_n`=0, `oe_n`=0 and `we_n`=1 were sampled, and 0 otherwise. In particular it is 0 whenever `ce_n` was 1, whatever `oe_n` was. `dout` is 0 while `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| sig_hv | input | 1 | Signature-row qualifier |
| clr_hv | input | 1 | Whole-array clear qualifier |
| low_vcc | input | 1 | Low-supply detect, blocks writes |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | Drive enable for `dout` |
| ready_o | output | 1 | 1 = ready, 0 = internal cycle running |

## Verification
Some properties are checked on every clock:
- `dout_oe` follows the strobes one clock later.
- An accepted start pulls `ready_o` low on the next clock.
- A rejected start, whether blocked or arriving during a cycle, leaves `ready_o` high.
- `ready_o` never rises until at least a full cycle length has passed.

Other behaviour needs the bench's scenarios, checked against its running reference model:
- which address and data end up stored when `addr` and `din` move around the strobe edges;
- the polled value, and the stored data at other addresses, during a cycle;
- that the signature row is kept separate from the main array and survives a whole-array clear.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_ERASE,
    ST_PROG,
    ST_SWEEP
  } eep_state_e;
endpackage

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int WC_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sig_sel,
  input  logic              clr_hv,
  input  logic              low_vcc,
  output logic              ready,
  output logic              poll_act,
  output logic [ADDR_W-1:0] lat_addr,
  output logic              lat_sig,
  output logic [DATA_W-1:0] lat_data,
  output logic              wr_en,
  output logic              wr_sig,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ERASE_C = WC_CYCLES / 2;
  localparam int PROG_C  = WC_CYCLES - ERASE_C;
  localparam int SPAN    = (DEPTH > WC_CYCLES) ? DEPTH : WC_CYCLES;
  localparam int CNT_W   = $clog2(SPAN) + 1;
  localparam logic [CNT_W-1:0] SWEEP_LAST = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ERASE_LD   = CNT_W'(ERASE_C - 1);
  localparam logic [CNT_W-1:0] PROG_LD    = CNT_W'(PROG_C - 1);

  eep_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             strb, strb_q, strb_fall, strb_rise;

  assign strb      = ce_n | we_n;
  assign strb_fall = strb_q & ~strb;
  assign strb_rise = ~strb_q & strb;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      strb_q   <= 1'b1;
      lat_addr <= '0;
      lat_sig  <= 1'b0;
      lat_data <= '0;
    end else begin
      strb_q <= strb;
      unique case (state)
        ST_IDLE: begin
          if (strb_fall && !low_vcc) begin
            if (clr_hv) begin
              state <= ST_SWEEP;
              cnt   <= '0;
            end else if (oe_n) begin
              state    <= ST_ARMED;
              lat_addr <= addr;
              lat_sig  <= sig_sel;
            end
          end
        end
        ST_ARMED: begin
          if (strb_rise) begin
            lat_data <= din;
            cnt      <= ERASE_LD;
            state    <= ST_ERASE;
          end
        end
        ST_ERASE: begin
          if (cnt == '0) begin
            cnt   <= PROG_LD;
            state <= ST_PROG;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PROG: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        ST_SWEEP: begin
          if (cnt == SWEEP_LAST) state <= ST_IDLE;
          else                   cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Single memory write port: byte clear, byte program or array sweep.
  always_comb begin
    wr_en   = 1'b0;
    wr_sig  = lat_sig;
    wr_addr = lat_addr;
    wr_data = '1;
    if (state == ST_ARMED && strb_rise) begin
      wr_en = 1'b1;
    end else if (state == ST_PROG && cnt == '0) begin
      wr_en   = 1'b1;
      wr_data = lat_data;
    end else if (state == ST_SWEEP) begin
      wr_en   = 1'b1;
      wr_sig  = 1'b0;
      wr_addr = cnt[ADDR_W-1:0];
    end
  end

  assign ready    = (state == ST_IDLE);
  assign poll_act = (state == ST_ERASE) || (state == ST_PROG);
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SIG_W  = 5
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_sig,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_sig,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int SIG_DEPTH = 1 << SIG_W;

  logic [DATA_W-1:0] main_mem [DEPTH];
  logic [DATA_W-1:0] sig_mem  [SIG_DEPTH];
  logic [DATA_W-1:0] main_q, sig_q;
  logic              rd_sig_q;

  always_ff @(posedge clk) begin
    if (wr_en && !wr_sig) main_mem[wr_addr] <= wr_data;
    main_q <= main_mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_sig) sig_mem[wr_addr[SIG_W-1:0]] <= wr_data;
    sig_q    <= sig_mem[rd_addr[SIG_W-1:0]];
    rd_sig_q <= rd_sig;
  end

  assign rd_data = rd_sig_q ? sig_q : main_q;
endmodule

// File: rtl/eeprom_core.sv
module eeprom_core #(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int SIG_BYTES = 32,
  parameter int WC_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              sig_hv,
  input  logic              clr_hv,
  input  logic              low_vcc,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe,
  output logic              ready_o
);
  localparam int SIG_W = $clog2(SIG_BYTES);

  logic              sig_sel, poll_act, lat_sig;
  logic [ADDR_W-1:0] lat_addr, wr_addr;
  logic [DATA_W-1:0] lat_data, wr_data, rdata;
  logic              wr_en, wr_sig;
  logic              oe_q, poll_q, pbit_q;

  assign sig_sel = sig_hv && (&addr[ADDR_W-1:SIG_W]);

  eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WC_CYCLES(WC_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .sig_sel(sig_sel), .clr_hv(clr_hv),
    .low_vcc(low_vcc), .ready(ready_o), .poll_act(poll_act),
    .lat_addr(lat_addr), .lat_sig(lat_sig), .lat_data(lat_data),
    .wr_en(wr_en), .wr_sig(wr_sig), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIG_W(SIG_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_sig(wr_sig), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_sig(sig_sel), .rd_data(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      poll_q <= 1'b0;
      pbit_q <= 1'b0;
    end else begin
      oe_q   <= !ce_n && !oe_n && we_n;
      poll_q <= poll_act && (addr == lat_addr) && (sig_sel == lat_sig);
      pbit_q <= ~lat_data[DATA_W-1];
    end
  end

  assign dout_oe = oe_q;
  assign dout    = !oe_q  ? '0 :
                   poll_q ? {pbit_q, {(DATA_W-1){1'b0}}} : rdata;
endmodule

// File: rtl/eeprom_core_chk.sv
module eeprom_core_chk #(
  parameter int ADDR_W    = 13,
  parameter int WC_CYCLES = 64
) (
  input logic clk,
  input logic rst,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic clr_hv,
  input logic low_vcc,
  input logic dout_oe,
  input logic ready_o
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int MIN_BUSY = (DEPTH < WC_CYCLES) ? DEPTH : WC_CYCLES;

  logic strb_q;
  int   busy_len;
  logic start_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q   <= 1'b1;
      busy_len <= 0;
    end else begin
      strb_q   <= ce_n | we_n;
      busy_len <= ready_o ? 0 : busy_len + 1;
    end
  end

  assign start_ok = strb_q && !(ce_n | we_n) && !low_vcc && (clr_hv || oe_n);

  // R2: accepted start drops ready on the next clock
  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_ok) |=> !ready_o);

  // R5 / R6: no accepted start means ready stays high
  p_inhibit_r5: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !start_ok) |=> ready_o);

  // R2: cycle never shorter than its programmed length
  p_min_busy_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> (busy_len >= MIN_BUSY));

  // R9: deselected means not driving
  p_hiz_r9: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !dout_oe);

  // R9: read strobes enable the output one clock later
  p_read_en_r9: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> dout_oe);

  // R9: never drives while writing
  p_no_drive_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !dout_oe);
endmodule

bind eeprom_core eeprom_core_chk #(.ADDR_W(ADDR_W), .WC_CYCLES(WC_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .clr_hv(clr_hv), .low_vcc(low_vcc), .dout_oe(dout_oe), .ready_o(ready_o)
);

// File: tb/eeprom_core_bench.sv
module eeprom_core_bench;
  localparam int AW    = 13;
  localparam int DEPTH = 1 << AW;
  localparam int WC    = 64;
  localparam int SIG0  = DEPTH - 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          sig_hv = 1'b0, clr_hv = 1'b0, low_vcc = 1'b0;
  logic [7:0]    dout;
  logic          dout_oe, ready_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  string cur_tag = "R9";

  always #4 clk = ~clk;

  eeprom_core #(.ADDR_W(AW), .DATA_W(8), .SIG_BYTES(32), .WC_CYCLES(WC)) u_eeprom_core (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .sig_hv(sig_hv), .clr_hv(clr_hv),
    .low_vcc(low_vcc), .dout(dout), .dout_oe(dout_oe), .ready_o(ready_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  int main_arr [DEPTH];
  int sig_arr  [32];
  int m_phase = 0;   // 0 idle, 1 armed, 2 timed cycle, 3 array sweep
  int m_left  = 0;
  int m_addr  = 0;
  bit m_sig   = 1'b0;
  int m_data  = 0;
  bit m_prev  = 1'b1;
  bit e_rdy   = 1'b1;
  bit e_oe    = 1'b0;
  bit e_known = 1'b0;
  int e_dat   = 0;

  initial begin
    for (int i = 0; i < DEPTH; i++) main_arr[i] = -1;
    for (int i = 0; i < 32; i++) sig_arr[i] = -1;
  end

  always @(posedge clk) begin
    bit strb, hit;
    int v;
    strb = ce_n | we_n;
    hit  = sig_hv && (int'(addr) >= SIG0);
    if (rst) begin
      m_phase = 0; m_prev = 1'b1; e_rdy = 1'b1; e_oe = 1'b0; e_known = 1'b0;
    end else begin
      e_oe = !ce_n && !oe_n && we_n;
      if (m_phase == 3) begin
        e_known = 1'b0;
      end else if (m_phase == 2 && int'(addr) == m_addr && hit == m_sig) begin
        e_known = 1'b1;
        e_dat   = (m_data & 8'h80) ? 8'h00 : 8'h80;
      end else begin
        v = hit ? sig_arr[int'(addr) - SIG0] : main_arr[int'(addr)];
        e_known = (v >= 0);
        e_dat   = v;
      end
      case (m_phase)
        0: if (m_prev && !strb && !low_vcc) begin
             if (clr_hv) begin m_phase = 3; m_left = DEPTH; end
             else if (oe_n) begin m_phase = 1; m_addr = int'(addr); m_sig = hit; end
           end
        1: if (strb) begin m_phase = 2; m_left = WC; m_data = int'(din); end
        2: begin
             m_left--;
             if (m_left == 0) begin
               if (m_sig) sig_arr[m_addr - SIG0] = m_data;
               else       main_arr[m_addr] = m_data;
               m_phase = 0;
             end
           end
        default: begin
             m_left--;
             if (m_left == 0) begin
               for (int i = 0; i < DEPTH; i++) main_arr[i] = 8'hFF;
               m_phase = 0;
             end
           end
      endcase
      m_prev = strb;
      e_rdy  = (m_phase == 0);
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 ready_o", ready_o, e_rdy);
      check("R9 dout_oe", dout_oe, e_oe);
      if (e_oe && e_known) check({cur_tag, " dout"}, dout, e_dat);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle_bus();
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic write_we(input int a, input int d, input bit s);
    sig_hv = s; oe_n = 1'b1; ce_n = 1'b0; addr = AW'(a);
    @(negedge clk); we_n = 1'b0; din = 8'(d);
    @(negedge clk); addr = ~AW'(a);              // R1: address already taken
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); din = ~8'(d);                // R1: data already taken
    ce_n = 1'b1; sig_hv = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_ce(input int a, input int d);
    oe_n = 1'b1; we_n = 1'b0; addr = AW'(a); din = 8'(d);
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); addr = ~AW'(a);
    @(negedge clk); ce_n = 1'b1;
    @(negedge clk); din = ~8'(d); we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input int a, input bit s, input int exp);
    cur_tag = tag;
    sig_hv = s; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; addr = AW'(a);
    @(negedge clk);
    check(tag, dout, exp);
    idle_bus(); sig_hv = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_ready();
    while (!ready_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chip_clear();
    clr_hv = 1'b1; oe_n = 1'b1; we_n = 1'b1; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; clr_hv = 1'b0;
    wait_ready();
  endtask

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    int lo;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 reset ready", ready_o, 1);
    check("R9 reset dout_oe", dout_oe, 0);

    // R8: whole-array clear
    chip_clear();
    read_chk("R8", 0, 0, 8'hFF);
    read_chk("R8", DEPTH - 1, 0, 8'hFF);

    // R7: signature row write, separate from main array
    write_we(SIG0 + 3, 8'h5A, 1'b1);
    wait_ready();
    read_chk("R7", SIG0 + 3, 1, 8'h5A);
    read_chk("R7", SIG0 + 3, 0, 8'hFF);

    // R1/R2/R3/R4: write-enable controlled write, polling during cycle
    write_we(16'h0123, 8'h3C, 1'b0);
    read_chk("R3", 16'h0123, 0, 8'h80);
    read_chk("R4", 16'h0200, 0, 8'hFF);
    lo = 0;
    while (!ready_o) begin lo++; @(negedge clk); end
    check("R2 busy span", (lo > 0 && lo < WC) ? 1 : 0, 1);
    @(negedge clk);
    read_chk("R1", 16'h0123, 0, 8'h3C);
    read_chk("R1", int'(~13'h0123), 0, 8'hFF);

    // R1/R6: chip-select controlled write, second attempt while busy
    write_ce(16'h0456, 8'hC3);
    read_chk("R3", 16'h0456, 0, 8'h00);
    write_we(16'h0789, 8'h11, 1'b0);
    wait_ready();
    read_chk("R6", 16'h0456, 0, 8'hC3);
    read_chk("R6", 16'h0789, 0, 8'hFF);

    // R5: output gate low at start
    cur_tag = "R5";
    ce_n = 1'b0; oe_n = 1'b0; addr = 13'h0300; din = 8'h77;
    @(negedge clk); we_n = 1'b0;
    @(negedge clk); check("R5 oe_n inhibit", ready_o, 1);
    we_n = 1'b1;
    @(negedge clk); idle_bus();
    @(negedge clk);
    read_chk("R5", 16'h0300, 0, 8'hFF);

    // R5: low supply
    low_vcc = 1'b1;
    write_we(16'h0301, 8'h66, 1'b0);
    check("R5 low_vcc inhibit", ready_o, 1);
    low_vcc = 1'b0;
    read_chk("R5", 16'h0301, 0, 8'hFF);

    // R9: deselected with output gate low
    ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk);
    check("R9 hiz", dout_oe, 0);
    idle_bus();
    @(negedge clk);

    // R8: clear again, signature row survives
    chip_clear();
    read_chk("R8", SIG0 + 3, 1, 8'h5A);
    read_chk("R8", 16'h0123, 0, 8'hFF);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule